// File: doc/BRIEF.md
# Boundary-Scan Register for Twelve Tristate Pins

This block is the data-register side of a boundary scan for a small device with twelve bidirectional pins. It holds a 108-cell serial chain. For each pin there is a group of three adjacent cells: an observe-only cell that records the pin level, a data cell for the driven value and an enable cell for the output driver. Every other position is an unused cell that always captures 0. An external test access port controller supplies one-cycle strobes that capture, shift and update the chain, and a two-bit pad-source code. The code decides whether the pads follow the core logic, follow the update latches, or have every driver turned off.

The pad outputs are registered. A per-pin pull flag reports which disabled pins sit at a weak high level instead of floating. Only the pins at group positions 42 and 45 have that weak pull. The block runs on one clock with a synchronous active-high reset. An update strobe loads the latches on a rising edge instead of on a separate falling-edge phase.

Top module: `bscan_pin_bsr`

## Requirements
- R1: While `rst` is high and after it is released, every cell and every update latch is 0. `pad_out` and `pad_oe` are 0, `pad_pull` equals 12'h030 and `scan_out` is 0.
- R2: On a clock with `shift_en` high and `cap_en` low, every cell k<107 takes the old value of cell k+1 and cell 107 takes `scan_in`. `scan_out` always shows cell 0. With no strobe, the chain holds.
- R3: On a clock with `cap_en` high, each pin p with enable cell at position E loads three cells: E takes `core_oe[p]`, E+1 takes `core_out[p]` and E+2 takes `pad_in[p]`. Every other cell loads 0. The enable positions for pins 0..11 are 3, 6, 27, 36, 42, 45, 66, 78, 81, 90, 96 and 99. Capture takes priority over shift.
- R4: On a clock with `upd_en` high, pin p's data latch loads cell E+1 and its enable latch loads cell E. Without `upd_en` the latches hold, so shifting never changes the pads.
- R5: When `pad_src` is 2'b00 (core), `pad_out` and `pad_oe` equal `core_out` and `core_oe` from the previous clock.
- R6: When `pad_src` is 2'b01 (external test) or 2'b11 (clamp), `pad_out` and `pad_oe` equal the data and enable latches from the previous clock. An enable value of 1 turns the driver on.
- R7: When `pad_src` is 2'b10 (high-impedance), `pad_oe` is all zero on the next clock, and `pad_out` follows the data latches.
- R8: `pad_pull[p]` is 1 exactly when `pad_oe[p]` is 0 and p is 4 or 5 (the weak-high pins). This holds in the same cycle as `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| pad_src | input | 2 | Pad source: 00 core, 01 external test, 10 high-impedance, 11 clamp |
| scan_in | input | 1 | Serial data into cell 107 |
| scan_out | output | 1 | Serial data from cell 0 |
| core_out | input | 12 | Core output values |
| core_oe | input | 12 | Core output enables |
| pad_in | input | 12 | Levels observed at the pins |
| pad_out | output | 12 | Registered pad output values |
| pad_oe | output | 12 | Registered pad driver enables, 1 drives |
| pad_pull | output | 12 | Disabled pin resolved to weak high |

## Verification
The core, pin and enable words used for the capture differ from one another, so a cell wired to the wrong source or the wrong offset shows up in the unloaded bit stream. The 108 bits shifted in do not repeat within a pin group, so the update latches receive mixed enable and data values. That makes an off-by-one update mapping visible on the pads in external-test mode. A second load that is shifted in without an update tells holding latches apart from leaking ones. The high-impedance, clamp and core phases switch `core_oe` between all ones and all zeros, which separates the pull flag of the two weak pins from the flags of the other ten.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned BSR_CELLS = 108;
  localparam int unsigned BSR_PINS  = 12;
  localparam int unsigned POS_W     = 8;

  // enable-cell position of each pin, pin 0 in the low byte
  localparam logic [BSR_PINS*POS_W-1:0] BSR_CTL_POS = {
    8'd99, 8'd96, 8'd90, 8'd81, 8'd78, 8'd66,
    8'd45, 8'd42, 8'd36, 8'd27, 8'd6,  8'd3
  };
  localparam logic [BSR_PINS-1:0] BSR_WEAK_MASK = 12'h030;

  typedef enum logic [1:0] {
    PADSRC_CORE   = 2'b00,
    PADSRC_EXTEST = 2'b01,
    PADSRC_HIGHZ  = 2'b10,
    PADSRC_CLAMP  = 2'b11
  } pad_src_e;
endpackage

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int unsigned N     = 108,
  parameter int unsigned P     = 12,
  parameter int unsigned POS_W = 8,
  parameter logic [P*POS_W-1:0] CTL_POS = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         scan_in,
  input  logic [P-1:0] pad_in,
  input  logic [P-1:0] core_out,
  input  logic [P-1:0] core_oe,
  output logic         ser_out,
  output logic [P-1:0] tap_out,
  output logic [P-1:0] tap_ctl
);
  logic [N-1:0] cells;
  logic [N-1:0] cap_vec;

  function automatic int cell_pin(input int c);
    for (int p = 0; p < int'(P); p++) begin
      if (c >= int'(CTL_POS[p*POS_W +: POS_W]) && c <= int'(CTL_POS[p*POS_W +: POS_W]) + 2)
        return p;
    end
    return -1;
  endfunction

  for (genvar c = 0; c < int'(N); c++) begin : g_cap
    localparam int PIN = cell_pin(c);
    if (PIN < 0) begin : g_int
      assign cap_vec[c] = 1'b0;
    end else begin : g_pin
      localparam int OFS = c - int'(CTL_POS[PIN*POS_W +: POS_W]);
      if (OFS == 0) begin : g_ctl
        assign cap_vec[c] = core_oe[PIN];
      end else if (OFS == 1) begin : g_dat
        assign cap_vec[c] = core_out[PIN];
      end else begin : g_obs
        assign cap_vec[c] = pad_in[PIN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cells <= '0;
    else if (cap_en)   cells <= cap_vec;
    else if (shift_en) cells <= {scan_in, cells[N-1:1]};
  end

  assign ser_out = cells[0];

  for (genvar p = 0; p < int'(P); p++) begin : g_tap
    localparam int POS = int'(CTL_POS[p*POS_W +: POS_W]);
    assign tap_ctl[p] = cells[POS];
    assign tap_out[p] = cells[POS+1];
  end

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cap_en) |=> (cells[N-2:0] == $past(cells[N-1:1]))) else $error("shift move"); // R2
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cap_en) |=> (cells[N-1] == $past(scan_in))) else $error("shift entry"); // R2
  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !cap_en) |=> $stable(cells)) else $error("chain hold"); // R2
endmodule

// File: rtl/bsr_update.sv
module bsr_update #(
  parameter int unsigned P = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_en,
  input  logic [P-1:0] tap_out,
  input  logic [P-1:0] tap_ctl,
  output logic [P-1:0] lat_out,
  output logic [P-1:0] lat_ctl
);
  for (genvar p = 0; p < int'(P); p++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) begin
        lat_out[p] <= 1'b0;
        lat_ctl[p] <= 1'b0;
      end else if (upd_en) begin
        lat_out[p] <= tap_out[p];
        lat_ctl[p] <= tap_ctl[p];
      end
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> ($stable(lat_ctl) && $stable(lat_out))) else $error("latch hold"); // R4
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (lat_ctl == $past(tap_ctl))) else $error("latch load"); // R4
endmodule

// File: rtl/bsr_padmux.sv
module bsr_padmux
  import bsr_pkg::*;
#(
  parameter int unsigned P = 12,
  parameter logic [P-1:0] WEAK_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   pad_src,
  input  logic [P-1:0] core_out,
  input  logic [P-1:0] core_oe,
  input  logic [P-1:0] lat_out,
  input  logic [P-1:0] lat_ctl,
  output logic [P-1:0] pad_out,
  output logic [P-1:0] pad_oe,
  output logic [P-1:0] pad_pull
);
  logic [P-1:0] nxt_out, nxt_oe;

  always_comb begin
    case (pad_src_e'(pad_src))
      PADSRC_CORE:  begin nxt_out = core_out; nxt_oe = core_oe; end
      PADSRC_HIGHZ: begin nxt_out = lat_out;  nxt_oe = '0;      end
      default:      begin nxt_out = lat_out;  nxt_oe = lat_ctl; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out  <= '0;
      pad_oe   <= '0;
      pad_pull <= WEAK_MASK;
    end else begin
      pad_out  <= nxt_out;
      pad_oe   <= nxt_oe;
      pad_pull <= ~nxt_oe & WEAK_MASK;
    end
  end

  AST_HIGHZ_OFF: assert property (@(posedge clk) disable iff (rst)
    (pad_src == PADSRC_HIGHZ) |=> (pad_oe == '0)) else $error("highz"); // R7
  AST_CORE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (pad_src == PADSRC_CORE) |=> (pad_oe == $past(core_oe) && pad_out == $past(core_out))) else $error("core follow"); // R5
  AST_TEST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (pad_src == PADSRC_EXTEST || pad_src == PADSRC_CLAMP) |=> (pad_oe == $past(lat_ctl))) else $error("test follow"); // R6
  AST_PULL_DISABLED: assert property (@(posedge clk) disable iff (rst)
    ((pad_pull & pad_oe) == '0)) else $error("pull while driving"); // R8
endmodule

// File: rtl/bscan_pin_bsr.sv
module bscan_pin_bsr
  import bsr_pkg::*;
#(
  parameter int unsigned N     = BSR_CELLS,
  parameter int unsigned P     = BSR_PINS,
  parameter int unsigned PW    = POS_W,
  parameter logic [P*PW-1:0] CTL_POS = BSR_CTL_POS,
  parameter logic [P-1:0] WEAK_MASK = BSR_WEAK_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         upd_en,
  input  logic [1:0]   pad_src,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic [P-1:0] core_out,
  input  logic [P-1:0] core_oe,
  input  logic [P-1:0] pad_in,
  output logic [P-1:0] pad_out,
  output logic [P-1:0] pad_oe,
  output logic [P-1:0] pad_pull
);
  logic [P-1:0] tap_out, tap_ctl, lat_out, lat_ctl;

  bsr_chain #(.N(N), .P(P), .POS_W(PW), .CTL_POS(CTL_POS)) i_chain (
    .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en), .scan_in(scan_in),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .ser_out(scan_out), .tap_out(tap_out), .tap_ctl(tap_ctl)
  );

  bsr_update #(.P(P)) i_update (
    .clk(clk), .rst(rst), .upd_en(upd_en), .tap_out(tap_out), .tap_ctl(tap_ctl),
    .lat_out(lat_out), .lat_ctl(lat_ctl)
  );

  bsr_padmux #(.P(P), .WEAK_MASK(WEAK_MASK)) i_padmux (
    .clk(clk), .rst(rst), .pad_src(pad_src), .core_out(core_out), .core_oe(core_oe),
    .lat_out(lat_out), .lat_ctl(lat_ctl),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && scan_out == 1'b0)) else $error("reset state"); // R1
endmodule

// File: tb/test_bscan_pin_bsr.sv
`timescale 1ns/1ps
module test_bscan_pin_bsr;
  localparam int NC = 108;
  localparam int NP = 12;
  localparam logic [11:0] WEAK = 12'h030;
  localparam logic [1:0] M_CORE = 2'b00, M_EXT = 2'b01, M_HIZ = 2'b10, M_CLAMP = 2'b11;
  int ctl_at [NP] = '{3, 6, 27, 36, 42, 45, 66, 78, 81, 90, 96, 99};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, scan_in = 1'b0;
  logic [1:0] pad_src = M_CORE;
  logic [11:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic scan_out;
  logic [11:0] pad_out, pad_oe, pad_pull;

  always #2 clk = ~clk;

  bscan_pin_bsr i_bscan_pin_bsr (
    .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
    .pad_src(pad_src), .scan_in(scan_in), .scan_out(scan_out),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull)
  );

  bit mq[$];
  logic [11:0] m_lo, m_lc, m_po, m_poe, m_pp;
  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [11:0] no, noe;
    if (rst) begin
      mq.delete();
      for (int i = 0; i < NC; i++) mq.push_back(1'b0);
      m_lo = '0; m_lc = '0; m_po = '0; m_poe = '0; m_pp = WEAK;
      return;
    end
    case (pad_src)
      M_CORE: begin no = core_out; noe = core_oe; end
      M_HIZ:  begin no = m_lo; noe = '0; end
      default: begin no = m_lo; noe = m_lc; end
    endcase
    m_po = no; m_poe = noe; m_pp = ~noe & WEAK;
    if (upd_en)
      for (int p = 0; p < NP; p++) begin
        m_lc[p] = mq[ctl_at[p]];
        m_lo[p] = mq[ctl_at[p] + 1];
      end
    if (cap_en) begin
      for (int i = 0; i < NC; i++) mq[i] = 1'b0;
      for (int p = 0; p < NP; p++) begin
        mq[ctl_at[p]]     = core_oe[p];
        mq[ctl_at[p] + 1] = core_out[p];
        mq[ctl_at[p] + 2] = pad_in[p];
      end
    end else if (shift_en) begin
      void'(mq.pop_front());
      mq.push_back(scan_in);
    end
  endtask

  task automatic compare_all();
    string t;
    t = (pad_src == M_CORE) ? "R5" : (pad_src == M_HIZ) ? "R7" : "R6";
    chk({t, " pad_oe"}, 32'(pad_oe), 32'(m_poe));
    chk({t, " pad_out"}, 32'(pad_out), 32'(m_po));
    chk("R8 pad_pull", 32'(pad_pull), 32'(m_pp));
    chk("R2 R3 scan_out", 32'(scan_out), 32'(mq[0]));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic pat_a(int i);
    return ((i * 5 + 1) % 3) == 0 || (i % 7) == 2;
  endfunction
  function automatic logic pat_b(int i);
    return ((i * 3 + 2) % 4) < 2;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] keep_out, keep_oe;
    @(negedge clk);
    repeat (3) cyc();
    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 pad_out", 32'(pad_out), 32'h0);
    chk("R1 pad_pull", 32'(pad_pull), 32'(WEAK));
    chk("R1 scan_out", 32'(scan_out), 32'h0);
    rst = 1'b0;
    cyc();

    // R5 core pass-through with varied patterns
    for (int i = 0; i < 6; i++) begin
      core_out = 12'(i * 12'h2B7 + 12'h15);
      core_oe  = 12'(12'hF0F ^ (i * 12'h093));
      cyc();
    end

    // R3 capture, then unload through R2 shifting
    pad_in = 12'hA5C; core_out = 12'h3C9; core_oe = 12'h6B1;
    cap_en = 1'b1; cyc(); cap_en = 1'b0;
    core_oe = '0;
    shift_en = 1'b1;
    for (int i = 0; i < NC; i++) begin scan_in = pat_a(i); cyc(); end
    shift_en = 1'b0;

    // R4 update, R6 external test drives latches
    upd_en = 1'b1; cyc(); upd_en = 1'b0;
    pad_src = M_EXT;
    repeat (3) cyc();

    // R4 shifting without update leaves pads untouched
    keep_out = pad_out; keep_oe = pad_oe;
    shift_en = 1'b1;
    for (int i = 0; i < NC; i++) begin scan_in = pat_b(i); cyc(); end
    shift_en = 1'b0;
    chk("R4 pad_oe held", 32'(pad_oe), 32'(keep_oe));
    chk("R4 pad_out held", 32'(pad_out), 32'(keep_out));
    upd_en = 1'b1; cyc(); upd_en = 1'b0;
    repeat (2) cyc();

    // R7 high-impedance, R8 pull flags
    pad_src = M_HIZ;
    repeat (3) cyc();
    chk("R7 all off", 32'(pad_oe), 32'h0);
    chk("R8 weak pins", 32'(pad_pull), 32'(WEAK));

    // R6 clamp
    pad_src = M_CLAMP;
    repeat (3) cyc();

    // R5 / R8 with core enables all on and all off
    pad_src = M_CORE; core_oe = 12'hFFF; core_out = 12'h5A5;
    repeat (2) cyc();
    chk("R8 none when driving", 32'(pad_pull), 32'h0);
    core_oe = 12'h000;
    repeat (2) cyc();
    chk("R8 weak when off", 32'(pad_pull), 32'(WEAK));

    // R3 capture has priority over shift
    pad_in = 12'h3F0; core_out = 12'h0CC; core_oe = 12'h951;
    cap_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1; cyc();
    cap_en = 1'b0;
    for (int i = 0; i < NC; i++) begin scan_in = pat_b(i + 3); cyc(); end
    shift_en = 1'b0;
    cyc();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule